// File: doc/BRIEF.md
# Sliding-Window Hashed Signature Scanner

This block screens a byte stream against a pre-loaded membership bitmap. Characters enter a four-character window one per clock. Each window position is folded by XOR into a 12-bit address. That address reads a 4096-entry bitmap memory. Any nonzero word read back raises a hit, which marks the window as a likely signature for a later exact check elsewhere.

A small controller sequences the datapath. It waits for `start_i`, then spends three cycles priming the window. It stays in a scan state for as long as `more_i` reports that more characters follow. After that it drains the read and compare stages for four cycles and raises `done_o`. A second `start_i` pulse returns it to idle.

The controller state changes on the falling clock edge and the datapath registers on the rising edge. Each enable therefore settles half a cycle before the datapath uses it. The bitmap is filled through a plain write port while the controller is idle.

Top module: `sig_scan_top`

## Requirements
- R1: On a rising edge with the shift enable (`ctrl_o[2]`) set, the window takes `char_i` as its newest byte in bits 7:0 and moves the older bytes up by one byte. With the shift enable clear, the window keeps its contents.
- R2: The bitmap address is the XOR of window bits 11:0, window bits 23:12, and window bits 31:24 zero-extended to 12 bits.
- R3: On a rising edge with the read enable (`ctrl_o[1]`) set, the bitmap word at the address formed from the current window is captured. That word reaches the comparator one cycle later.
- R4: On a rising edge with the compare enable (`ctrl_o[0]`) set, `hit_o` becomes 1 if the captured word is nonzero and 0 if it is zero. With the compare enable clear, `hit_o` holds its value.
- R5: `hit_valid_o` is high in exactly those cycles that follow a rising edge at which the compare enable was set.
- R6: While `rst_ni` is low, `ctrl_o`, `done_o`, `hit_o` and `hit_valid_o` are 0. The window and the read register are also cleared.
- R7: From idle (`ctrl_o` = 0 and `done_o` = 0) the controller leaves only when `start_i` is high at a falling edge. It then spends three cycles with `ctrl_o` = 3'b100 (bit 2 shift, bit 1 read, bit 0 compare).
- R8: In the scan state `ctrl_o` = 3'b111. The controller stays in that state while `more_i` is high at the falling edge and leaves when it is low.
- R9: After the scan state come four cycles with `ctrl_o` = 3'b011. Then the controller enters a finished state with `ctrl_o` = 0 and `done_o` = 1. It stays there until `start_i` is high at a falling edge, and then goes to idle.
- R10: `ctrl_o` and `done_o` change only on falling clock edges. They stay stable across every rising edge.
- R11: A rising edge with `wr_en_i` high stores `wr_data_i` at `wr_addr_i`. Reads at later edges return the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; datapath on rising edge, controller on falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a scan from idle; release from finished state |
| more_i | input | 1 | More characters follow the current one |
| char_i | input | 8 | Incoming character |
| wr_en_i | input | 1 | Bitmap write strobe |
| wr_addr_i | input | 12 | Bitmap write address |
| wr_data_i | input | 4 | Bitmap write word |
| ctrl_o | output | 3 | Enables: bit 2 shift, bit 1 read, bit 0 compare |
| done_o | output | 1 | Scan sequence complete |
| hit_o | output | 1 | Last compared bitmap word was nonzero |
| hit_valid_o | output | 1 | `hit_o` refreshed on the previous rising edge |

## Verification
The checker watches several properties on every cycle:
- the validity flag trails the compare enable by one cycle;
- the hit and the window hold while their enables are off;
- the controller leaves idle only on `start_i` and enters fill with shifting alone;
- the scan state persists while `more_i` is high;
- `done_o` is never high together with an enable.

Some behaviour only the bench scenarios can show: the XOR fold, which bitmap entry each window position reads, the three-edge latency from a byte to its hit, the exact drain length, and the effect of rewriting an entry between scans. The bench drives random strings and bitmaps, a directed signature, a minimum four-character scan and long waits in idle and finished states. It checks each of these cycle by cycle against a model built from the requirements.

// File: rtl/sig_scan_pkg.sv
package sig_scan_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_FILL1, ST_FILL2, ST_FILL3, ST_SCAN,
    ST_DRN1, ST_DRN2, ST_DRN3, ST_DRN4, ST_DONE
  } scan_state_e;

  localparam int CTRL_W   = 3;
  localparam int BIT_SHIFT = 2;
  localparam int BIT_READ  = 1;
  localparam int BIT_COMP  = 0;

  localparam logic [CTRL_W-1:0] CV_NONE  = 3'b000;
  localparam logic [CTRL_W-1:0] CV_FILL  = 3'b100;
  localparam logic [CTRL_W-1:0] CV_SCAN  = 3'b111;
  localparam logic [CTRL_W-1:0] CV_DRAIN = 3'b011;
endpackage

// File: rtl/sig_window.sv
module sig_window #(
  parameter int CHAR_W = 8,
  parameter int TAPS   = 4,
  localparam int WIN_W = CHAR_W * TAPS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [CHAR_W-1:0] char_i,
  output logic [WIN_W-1:0]  win_o
);
  logic [WIN_W-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      win_q <= '0;
    else if (shift_i) win_q <= {win_q[WIN_W-CHAR_W-1:0], char_i};
  end

  assign win_o = win_q;
endmodule

// File: rtl/sig_fold_hash.sv
module sig_fold_hash #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 12,
  localparam int SLICES = (IN_W + OUT_W - 1) / OUT_W,
  localparam int PAD_W  = SLICES * OUT_W
) (
  input  logic [IN_W-1:0]  data_i,
  output logic [OUT_W-1:0] hash_o
);
  logic [PAD_W-1:0] padded;
  logic [OUT_W-1:0] part [SLICES+1];

  always_comb begin
    padded = '0;
    padded[IN_W-1:0] = data_i;
  end

  assign part[0] = '0;
  for (genvar g = 0; g < SLICES; g++) begin : g_fold
    assign part[g+1] = part[g] ^ padded[g*OUT_W +: OUT_W];
  end

  assign hash_o = part[SLICES];
endmodule

// File: rtl/sig_bitmap.sv
module sig_bitmap #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= mem[rd_addr_i];
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/sig_ctrl.sv
module sig_ctrl
  import sig_scan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              more_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              done_o
);
  scan_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_FILL1;
      ST_FILL1: state_d = ST_FILL2;
      ST_FILL2: state_d = ST_FILL3;
      ST_FILL3: state_d = ST_SCAN;
      ST_SCAN:  if (!more_i) state_d = ST_DRN1;
      ST_DRN1:  state_d = ST_DRN2;
      ST_DRN2:  state_d = ST_DRN3;
      ST_DRN3:  state_d = ST_DRN4;
      ST_DRN4:  state_d = ST_DONE;
      ST_DONE:  if (start_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // half-cycle offset: enables settle before the datapath edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    unique case (state_q)
      ST_FILL1, ST_FILL2, ST_FILL3:     ctrl_o = CV_FILL;
      ST_SCAN:                          ctrl_o = CV_SCAN;
      ST_DRN1, ST_DRN2, ST_DRN3, ST_DRN4: ctrl_o = CV_DRAIN;
      default:                          ctrl_o = CV_NONE;
    endcase
  end

  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/sig_scan_top.sv
module sig_scan_top
  import sig_scan_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int TAPS   = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 4,
  localparam int WIN_W = CHAR_W * TAPS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              more_i,
  input  logic [CHAR_W-1:0] char_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              done_o,
  output logic              hit_o,
  output logic              hit_valid_o
);
  logic [CTRL_W-1:0] ctrl;
  logic [WIN_W-1:0]  win_w;
  logic [ADDR_W-1:0] hash_w;
  logic [DATA_W-1:0] rd_word;
  logic              hit_q, hit_vld_q;

  sig_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .more_i  (more_i),
    .ctrl_o  (ctrl),
    .done_o  (done_o)
  );

  sig_window #(.CHAR_W(CHAR_W), .TAPS(TAPS)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (ctrl[BIT_SHIFT]),
    .char_i  (char_i),
    .win_o   (win_w)
  );

  sig_fold_hash #(.IN_W(WIN_W), .OUT_W(ADDR_W)) u_hash (
    .data_i (win_w),
    .hash_o (hash_w)
  );

  sig_bitmap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (ctrl[BIT_READ]),
    .rd_addr_i (hash_w),
    .rd_data_o (rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q     <= 1'b0;
      hit_vld_q <= 1'b0;
    end else begin
      if (ctrl[BIT_COMP]) hit_q <= |rd_word;
      hit_vld_q <= ctrl[BIT_COMP];
    end
  end

  assign ctrl_o      = ctrl;
  assign hit_o       = hit_q;
  assign hit_valid_o = hit_vld_q;
endmodule

// File: rtl/sig_scan_chk.sv
module sig_scan_chk #(
  parameter int WIN_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             more_i,
  input logic [2:0]       ctrl_i,
  input logic             done_i,
  input logic             hit_i,
  input logic             hit_valid_i,
  input logic [WIN_W-1:0] win_i
);
  // R5
  valid_follows_comp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[0] |=> hit_valid_i);
  // R5
  valid_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[0] |=> !hit_valid_i);
  // R4
  hit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[0] |=> $stable(hit_i));
  // R1
  win_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[2] |=> $stable(win_i));
  // R7
  idle_wait_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (ctrl_i == 3'b000 && !done_i && !start_i) |=> (ctrl_i == 3'b000 && !done_i));
  // R7
  idle_leave_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (ctrl_i == 3'b000 && !done_i && start_i) |=> (ctrl_i == 3'b100));
  // R8
  scan_stay_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (ctrl_i == 3'b111 && more_i) |=> (ctrl_i == 3'b111));
  // R9
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (ctrl_i == 3'b000));
endmodule

bind sig_scan_top sig_scan_chk #(.WIN_W(CHAR_W * TAPS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .more_i      (more_i),
  .ctrl_i      (ctrl_o),
  .done_i      (done_o),
  .hit_i       (hit_o),
  .hit_valid_i (hit_valid_o),
  .win_i       (win_w)
);

// File: tb/tb_sig_scan_top.sv
module tb_sig_scan_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, more_i = 1'b0;
  logic [7:0]  char_i = '0;
  logic        wr_en_i = 1'b0;
  logic [11:0] wr_addr_i = '0;
  logic [3:0]  wr_data_i = '0;
  logic [2:0]  ctrl_o;
  logic        done_o, hit_o, hit_valid_o;

  int checks = 0, errors = 0;
  int obs_hits = 0, exp_hits = 0;

  logic        m_mem [4096];
  logic [31:0] m_win = '0;
  logic        m_rd = 1'b0, m_hit = 1'b0, m_val = 1'b0;
  int          m_st = 0;
  logic [7:0]  sbuf [32];

  sig_scan_top dut (.*);

  always #4 clk_i = ~clk_i;

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [11:0] fold(input logic [31:0] w);
    logic [11:0] a = '0;
    for (int i = 0; i < 32; i++) a[i % 12] ^= w[i];
    return a;
  endfunction

  function automatic logic [2:0] ctl_of(input int s);
    if (s >= 1 && s <= 3) return 3'b100;
    if (s == 4)           return 3'b111;
    if (s >= 5 && s <= 8) return 3'b011;
    return 3'b000;
  endfunction

  function automatic int nxt(input int s, input logic st, input logic nc);
    case (s)
      0: return st ? 1 : 0;
      4: return nc ? 4 : 5;
      9: return st ? 0 : 9;
      default: return s + 1;
    endcase
  endfunction

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic cyc(input logic st, input logic nc, input logic [7:0] ch);
    logic [2:0] c;
    start_i = st; more_i = nc; char_i = ch;
    @(posedge clk_i);
    c = ctl_of(m_st);
    if (c[0]) m_hit = m_rd;
    m_val = c[0];
    if (c[1]) m_rd = m_mem[fold(m_win)];
    if (c[2]) m_win = {m_win[23:0], ch};
    #1;
    chk(ctrl_o == c, "R10 ctrl across rising edge", ctrl_o, c);
    @(negedge clk_i);
    m_st = nxt(m_st, st, nc);
    #1;
    c = ctl_of(m_st);
    chk(ctrl_o == c, (m_st == 4) ? "R8 ctrl" : (m_st <= 3) ? "R7 ctrl" : "R9 ctrl", ctrl_o, c);
    chk(done_o == (m_st == 9), "R9 done", done_o, m_st == 9);
    chk(hit_valid_o == m_val, "R5 valid", hit_valid_o, m_val);
    chk(hit_o == m_hit, "R1 R2 R3 R4 hit", hit_o, m_hit);
    if (hit_o && hit_valid_o) obs_hits++;
    if (m_hit && m_val) exp_hits++;
  endtask

  task automatic wr(input logic [11:0] a, input logic [3:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    cyc(1'b0, 1'b0, 8'h00);
    m_mem[a] = (d != 0);
    wr_en_i = 1'b0;
  endtask

  task automatic scan(input int n);
    int idx = 0;
    int guard = 0;
    cyc(1'b1, 1'b0, 8'h00);
    while (m_st != 9 && guard < 200) begin
      logic [2:0] c = ctl_of(m_st);
      logic [7:0] ch = $urandom;
      if (c[2] && idx < n) begin
        ch = sbuf[idx];
        idx++;
      end
      cyc(1'b0, idx < n, ch);
      guard++;
    end
    chk(m_st == 9 && idx == n, "R8 R9 scan consumed all characters", idx, n);
    cyc(1'b0, 1'b0, 8'h00);
    cyc(1'b0, 1'b0, 8'h00);
    cyc(1'b1, 1'b0, 8'h00);
  endtask

  initial begin
    logic [11:0] sig_a;
    int h0;
    void'($urandom(32'h5ca7_1e01));
    for (int i = 0; i < 4096; i++) m_mem[i] = 1'b0;

    // R6: reset state
    #3;
    chk(ctrl_o == 3'b000 && !done_o, "R6 ctrl/done in reset", {ctrl_o, done_o}, 0);
    chk(!hit_o && !hit_valid_o, "R6 hit in reset", {hit_o, hit_valid_o}, 0);
    repeat (3) @(negedge clk_i);
    #1; rst_ni = 1'b1;

    // R11: fill bitmap, sparse random nonzero words
    for (int a = 0; a < 4096; a++) begin
      logic [3:0] d = (($urandom % 16) == 0) ? 4'(($urandom % 15) + 1) : 4'h0;
      wr(12'(a), d);
    end

    // R7: idle with no start stays idle
    repeat (5) cyc(1'b0, 1'b1, 8'hff);

    // R3 R11: directed signature
    sig_a = fold({8'h45, 8'h56, 8'h49, 8'h4c});
    wr(sig_a, 4'h9);
    sbuf[0] = 8'h45; sbuf[1] = 8'h56; sbuf[2] = 8'h49; sbuf[3] = 8'h4c;
    h0 = obs_hits;
    scan(4);
    chk(obs_hits > h0, "R3 signature window produced a hit", obs_hits - h0, 1);

    // R11: clear entry, rescan; count must follow model
    wr(sig_a, 4'h0);
    scan(4);
    chk(obs_hits == exp_hits, "R11 hit count after rewrite", obs_hits, exp_hits);

    // R1 R2 R4: random strings of varying lengths
    for (int t = 0; t < 40; t++) begin
      int n = 4 + ($urandom % 28);
      for (int i = 0; i < n; i++) sbuf[i] = $urandom;
      if (t % 4 == 0) begin
        logic [31:0] w = {sbuf[0], sbuf[1], sbuf[2], sbuf[3]};
        wr(fold(w), 4'h1);
      end
      scan(n);
    end

    // R9: finished state waits for start
    sbuf[0] = 8'h01; sbuf[1] = 8'h02; sbuf[2] = 8'h03; sbuf[3] = 8'h04; sbuf[4] = 8'h05;
    cyc(1'b1, 1'b0, 8'h00);
    while (m_st != 9) begin
      logic [2:0] c = ctl_of(m_st);
      cyc(1'b0, m_st < 4 || (m_st == 4 && 1'b0), c[2] ? 8'h5a : 8'h00);
    end
    repeat (6) cyc(1'b0, 1'b1, 8'h00);
    cyc(1'b1, 1'b0, 8'h00);
    chk(ctrl_o == 3'b000 && !done_o, "R9 back to idle after start", {ctrl_o, done_o}, 0);

    chk(obs_hits == exp_hits, "R4 total hit count", obs_hits, exp_hits);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule